// File: doc/BRIEF.md
# Vector Load/Store Sequencer with Value-Based Early Stop

This block walks a vector memory operation one element at a time, from element 0 up to the requested vector length. For element i it reads a base pointer from register `(ra + i) mod NREGS`, adds a signed immediate, and makes one 64-bit access on a single-outstanding memory port. A load writes the returned word into register `(rt + i) mod NREGS`. A store sends register `(rt + i) mod NREGS` to memory. The word that moves, loaded or stored, is classified into a 4-bit condition field that is kept for that element.

The caller selects one bit of the condition field and a test value. The first element whose selected bit equals the test value ends the loop, and the vector length is cut back. In inclusive mode the failing element still counts. In exclusive mode it does not, and for a store the failing word is never written to memory. A load writes its destination register before the next element reads its base register. With `rt = ra + 1` the block therefore follows a linked list, one node per element.

The register file sits inside the block. A plain write port preloads it and a read port observes it while the sequencer is idle.

Top module: `vec_trunc_lsu`

## Requirements
- R1: Element i issues exactly one memory request, at address reg[(ra+i) mod 16] + imm. The request is high for one cycle, with `mem_we`=1 for a store and 0 for a load. The next request waits until `mem_rvalid` has answered the previous one, and no request is made while idle.
- R2: A load writes `mem_rdata` into reg[(rt+i) mod 16] before element i+1 reads its base register, so `rt = ra+1` chases pointers.
- R3: The condition field of element i sits at `cr_fields[4i+3:4i]`. Bit 3 is set when the data is negative (signed), bit 2 when it is above zero, bit 1 when it is zero, and bit 0 is always 0. Fields of elements not reached are 0 after a start.
- R4: `test_sel` (0..3) picks a field bit. The first element whose picked bit equals `test_val` stops the loop, and no later element touches memory or registers.
- R5: On a stop at element i, `vl_out` is i+1 when `inclusive`=1 and i when it is 0. With no stop, `vl_out` equals `vl_in`.
- R6: For a store with `inclusive`=0, the failing element is not written to memory. Its condition field is still recorded.
- R7: For a store with `inclusive`=1, the failing element is written to memory, and then the loop stops.
- R8: A start with `vl_in`=0 raises `done` at the next edge with `vl_out`=0, and makes no memory access.
- R9: A start while a run is in progress has no effect. `done` and `vl_out` hold their values until the next accepted start, and `done` drops when a start with nonzero length is accepted.
- R10: Counting the edge that takes the start as cycle 1, `done` is high after cycle 2k+1, where k is the number of memory accesses. A stop on an unwritten store adds one cycle.
- R11: After reset, `done`=0, `vl_out`=0, every condition field is 0 and `mem_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run |
| vl_in | input | 4 | Requested vector length, 0..8 |
| is_store | input | 1 | 1 = store, 0 = load |
| ra_idx | input | 4 | First base-pointer register |
| rt_idx | input | 4 | First data register (destination or source) |
| imm | input | 64 | Offset added to each base pointer |
| test_sel | input | 2 | Condition field bit to test |
| test_val | input | 1 | Value of that bit that stops the loop |
| inclusive | input | 1 | Keep the failing element in the length |
| vl_out | output | 4 | Resulting vector length |
| cr_fields | output | 32 | Condition fields, 4 bits per element |
| done | output | 1 | Run finished, result valid |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 64 | Store data |
| mem_rdata | input | 64 | Load data, valid with mem_rvalid |
| mem_rvalid | input | 1 | Response one cycle after a request |
| rf_we | input | 1 | Register preload write enable |
| rf_waddr | input | 4 | Register preload index |
| rf_wdata | input | 64 | Register preload data |
| rf_raddr | input | 4 | Register observe index |
| rf_rdata | output | 64 | Register observe data |

## Verification
Each element takes two cycles: a request edge, then a response edge that records the result. `done` is therefore due after cycle 2k+1 from the start edge. A store rejected in exclusive mode ends one edge after its request slot, with no access made. The bench counts edges from the start and samples every output on the falling edge. It checks the exact cycle `done` appears, then compares `vl_out`, all condition fields, the access count and every destination register or memory word against values it derives from the data pattern. Sweeps cover every stop position, both inclusive settings, several test bits, pointer chasing, register-index wrap, zero length and a start made during a run.

// File: rtl/vtl_pkg.sv
// Shared definitions for the vector load/store sequencer.
// Assumes: condition field layout is fixed at 4 bits per element.
package vtl_pkg;
    localparam int CR_W  = 4;
    localparam int CR_LT = 3;
    localparam int CR_GT = 2;
    localparam int CR_EQ = 1;
    localparam int CR_SO = 0;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT
    } seq_state_e;
endpackage

// File: rtl/vtl_regfile.sv
// Small register file: two sequencer read ports, one observe read port,
// one sequencer write port and one preload write port.
// Assumes: the sequencer write wins when both write ports hit together.
module vtl_regfile #(
    parameter int DW    = 64,
    parameter int NREGS = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(NREGS)-1:0] rd0_addr,
    output logic [DW-1:0]            rd0_data,
    input  logic [$clog2(NREGS)-1:0] rd1_addr,
    output logic [DW-1:0]            rd1_data,
    input  logic [$clog2(NREGS)-1:0] rd2_addr,
    output logic [DW-1:0]            rd2_data,
    input  logic                     wr_en,
    input  logic [$clog2(NREGS)-1:0] wr_addr,
    input  logic [DW-1:0]            wr_data,
    input  logic                     ext_we,
    input  logic [$clog2(NREGS)-1:0] ext_waddr,
    input  logic [DW-1:0]            ext_wdata
);
    localparam int AW = $clog2(NREGS);

    logic [DW-1:0] regs [NREGS];

    // Storage update: sequencer write first, preload second.
    always_ff @(posedge clk) begin
        for (int k = 0; k < NREGS; k++) begin
            if (!rst_n)
                regs[k] <= '0;
            else if (wr_en && wr_addr == AW'(k))
                regs[k] <= wr_data;
            else if (ext_we && ext_waddr == AW'(k))
                regs[k] <= ext_wdata;
        end
    end

    // Asynchronous read ports.
    assign rd0_data = regs[rd0_addr];
    assign rd1_data = regs[rd1_addr];
    assign rd2_data = regs[rd2_addr];
endmodule

// File: rtl/vtl_condgen.sv
// Classifies one data word into a 4-bit condition field
// (negative, positive, zero, summary-overflow held at 0).
// Assumes: data is a two's-complement signed value.
module vtl_condgen
    import vtl_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic [DW-1:0]   data,
    output logic [CR_W-1:0] field
);
    // Signed compare against zero.
    always_comb begin
        field        = '0;
        field[CR_LT] = data[DW-1];
        field[CR_EQ] = (data == '0);
        field[CR_GT] = !data[DW-1] && (data != '0);
        field[CR_SO] = 1'b0;
    end
endmodule

// File: rtl/vec_trunc_lsu.sv
// Sequencer for a vector load or store that stops early on a data test.
// One memory access is outstanding at a time; each element takes an
// issue cycle and a response cycle.
// Assumes: vl_in <= MAX_VL; memory answers every request with rvalid one
// cycle later (writes included); preload and observe ports are used only
// while no run is in progress.
module vec_trunc_lsu
    import vtl_pkg::*;
#(
    parameter int DW     = 64,
    parameter int NREGS  = 16,
    parameter int MAX_VL = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [$clog2(MAX_VL+1)-1:0] vl_in,
    input  logic                        is_store,
    input  logic [$clog2(NREGS)-1:0]    ra_idx,
    input  logic [$clog2(NREGS)-1:0]    rt_idx,
    input  logic [DW-1:0]               imm,
    input  logic [1:0]                  test_sel,
    input  logic                        test_val,
    input  logic                        inclusive,
    output logic [$clog2(MAX_VL+1)-1:0] vl_out,
    output logic [MAX_VL*CR_W-1:0]      cr_fields,
    output logic                        done,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [DW-1:0]               mem_addr,
    output logic [DW-1:0]               mem_wdata,
    input  logic [DW-1:0]               mem_rdata,
    input  logic                        mem_rvalid,
    input  logic                        rf_we,
    input  logic [$clog2(NREGS)-1:0]    rf_waddr,
    input  logic [DW-1:0]               rf_wdata,
    input  logic [$clog2(NREGS)-1:0]    rf_raddr,
    output logic [DW-1:0]               rf_rdata
);
    localparam int AW  = $clog2(NREGS);
    localparam int VLW = $clog2(MAX_VL+1);
    localparam int IW  = (MAX_VL > 1) ? $clog2(MAX_VL) : 1;

    seq_state_e                     state;
    logic [VLW-1:0]                 idx, vl_cap;
    logic                           st_cap, tv_cap, inc_cap;
    logic [AW-1:0]                  ra_cap, rt_cap;
    logic [DW-1:0]                  imm_cap;
    logic [1:0]                     sel_cap;
    logic [MAX_VL-1:0][CR_W-1:0]    cr_q;

    logic [AW-1:0]   ra_el, rt_el;
    logic [DW-1:0]   base_val, src_val, chk_data;
    logic [CR_W-1:0] fld;
    logic            hit, last, st_reject, ld_wr;

    // Per-element register indices wrap modulo the file size.
    assign ra_el = ra_cap + AW'(idx);
    assign rt_el = rt_cap + AW'(idx);

    vtl_regfile #(.DW(DW), .NREGS(NREGS)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd0_addr  (ra_el),
        .rd0_data  (base_val),
        .rd1_addr  (rt_el),
        .rd1_data  (src_val),
        .rd2_addr  (rf_raddr),
        .rd2_data  (rf_rdata),
        .wr_en     (ld_wr),
        .wr_addr   (rt_el),
        .wr_data   (mem_rdata),
        .ext_we    (rf_we),
        .ext_waddr (rf_waddr),
        .ext_wdata (rf_wdata)
    );

    // Tested word: store source, or the returned load data.
    assign chk_data = st_cap ? src_val : mem_rdata;

    vtl_condgen #(.DW(DW)) u_cond (
        .data  (chk_data),
        .field (fld)
    );

    // Test outcome and loop-end detection.
    assign hit       = (fld[sel_cap] == tv_cap);
    assign last      = ((idx + VLW'(1)) == vl_cap);
    assign st_reject = st_cap && hit && !inc_cap;
    assign ld_wr     = (state == ST_WAIT) && mem_rvalid && !st_cap;

    // Memory port drive: one request per issue cycle unless the store is rejected.
    assign mem_req   = (state == ST_ISSUE) && !st_reject;
    assign mem_we    = (state == ST_ISSUE) && st_cap;
    assign mem_addr  = base_val + imm_cap;
    assign mem_wdata = src_val;

    assign cr_fields = cr_q;

    // Sequencer state, captured operands and results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            idx     <= '0;
            vl_cap  <= '0;
            st_cap  <= 1'b0;
            tv_cap  <= 1'b0;
            inc_cap <= 1'b0;
            ra_cap  <= '0;
            rt_cap  <= '0;
            imm_cap <= '0;
            sel_cap <= '0;
            cr_q    <= '0;
            vl_out  <= '0;
            done    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        vl_cap  <= vl_in;
                        st_cap  <= is_store;
                        tv_cap  <= test_val;
                        inc_cap <= inclusive;
                        ra_cap  <= ra_idx;
                        rt_cap  <= rt_idx;
                        imm_cap <= imm;
                        sel_cap <= test_sel;
                        cr_q    <= '0;
                        idx     <= '0;
                        if (vl_in == '0) begin
                            vl_out <= '0;
                            done   <= 1'b1;
                        end else begin
                            done  <= 1'b0;
                            state <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (st_cap)
                        cr_q[idx[IW-1:0]] <= fld;
                    if (st_reject) begin
                        vl_out <= idx;
                        done   <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (mem_rvalid) begin
                        if (!st_cap)
                            cr_q[idx[IW-1:0]] <= fld;
                        if (hit) begin
                            vl_out <= inc_cap ? idx + VLW'(1) : idx;
                            done   <= 1'b1;
                            state  <= ST_IDLE;
                        end else if (last) begin
                            vl_out <= vl_cap;
                            done   <= 1'b1;
                            state  <= ST_IDLE;
                        end else begin
                            idx   <= idx + VLW'(1);
                            state <= ST_ISSUE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: a request is never followed directly by another one.
    assert_single_access_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R1: no memory traffic while idle.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !mem_req);

    // R3: the field of an element in flight is one-hot in its top three bits, bit 0 clear.
    assert_field_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ISSUE && st_cap) |-> ($onehot(fld[3:1]) && !fld[0]));

    // R5: a finished length never exceeds the requested one.
    assert_len_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (vl_out <= vl_cap));

    // R6: a failing store in exclusive mode never reaches memory.
    assert_no_bad_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !(hit && !inc_cap));

    // R8: zero length finishes on the next edge with zero length.
    assert_zero_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && vl_in == '0) |=> (done && vl_out == '0));

    // R9: results hold while no new start arrives.
    assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(vl_out)));

    // R9: a start during a run leaves the captured length alone.
    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && start) |=> $stable(vl_cap));
endmodule

// File: tb/vec_trunc_lsu_test.sv
`timescale 1ns/1ps
module vec_trunc_lsu_test;
    localparam logic [63:0] SENT = 64'hDEAD_BEEF_0BAD_F00D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  vl_in = '0;
    logic        is_store = 1'b0;
    logic [3:0]  ra_idx = '0, rt_idx = '0;
    logic [63:0] imm = '0;
    logic [1:0]  test_sel = '0;
    logic        test_val = 1'b0, inclusive = 1'b0;
    logic [3:0]  vl_out;
    logic [31:0] cr_fields;
    logic        done, mem_req, mem_we;
    logic [63:0] mem_addr, mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic        mem_rvalid = 1'b0;
    logic        rf_we = 1'b0;
    logic [3:0]  rf_waddr = '0, rf_raddr = '0;
    logic [63:0] rf_wdata = '0, rf_rdata;

    int n_chk = 0, n_fail = 0, cyc = 0, acc_cnt = 0, wd = 0;
    logic [63:0] mem [128];
    logic [63:0] dv [8];

    always #2.5 clk = ~clk;

    vec_trunc_lsu uut (
        .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in), .is_store(is_store),
        .ra_idx(ra_idx), .rt_idx(rt_idx), .imm(imm), .test_sel(test_sel),
        .test_val(test_val), .inclusive(inclusive), .vl_out(vl_out),
        .cr_fields(cr_fields), .done(done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rvalid(mem_rvalid), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata)
    );

    // Memory model: one-cycle response for every request.
    always @(posedge clk) begin
        mem_rvalid <= mem_req;
        if (mem_req) begin
            acc_cnt <= acc_cnt + 1;
            if (mem_we) mem[mem_addr[9:3]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:3]];
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", wd);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] cr_of(input logic [63:0] d);
        return {($signed(d) < 0), ($signed(d) > 0), (d == 0), 1'b0};
    endfunction

    task automatic set_reg(input int r, input logic [63:0] v);
        @(negedge clk);
        rf_we = 1'b1; rf_waddr = 4'(r); rf_wdata = v;
        @(posedge clk);
        @(negedge clk);
        rf_we = 1'b0;
    endtask

    task automatic get_reg(input int r, output logic [63:0] v);
        @(negedge clk);
        rf_raddr = 4'(r);
        #0.5 v = rf_rdata;
    endtask

    // Pulse start and count edges until done is seen on a falling edge.
    task automatic launch(input int vl, input bit st, input int ra, input int rt,
                          input logic [63:0] iv, input int sel, input bit tv, input bit inc);
        @(negedge clk);
        vl_in = 4'(vl); is_store = st; ra_idx = 4'(ra); rt_idx = 4'(rt); imm = iv;
        test_sel = 2'(sel); test_val = tv; inclusive = inc; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 200) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
    endtask

    // One full case driven by dv[]; all expectations derived here.
    task automatic run_case(input bit st, input int vl, input int sel, input bit tv,
                            input bit inc, input int ra, input int rt, input int iw);
        int fidx, pc, acc, acc0, exp_cyc;
        logic [31:0] exp_cr;
        logic [63:0] v, e;
        for (int i = 0; i < 8; i++) begin
            if (i < vl) set_reg((ra + i) % 16, 64'(8 * i));
            if (st) begin
                set_reg((rt + i) % 16, dv[i]);
                mem[iw + i] = SENT;
            end else begin
                set_reg((rt + i) % 16, SENT);
                mem[iw + i] = dv[i];
            end
        end
        fidx = vl;
        for (int i = vl - 1; i >= 0; i--)
            if (cr_of(dv[i])[sel] == tv) fidx = i;
        pc = (fidx < vl) ? fidx + 1 : vl;
        if (st && fidx < vl && !inc) acc = fidx;
        else acc = pc;
        exp_cyc = 2 * acc + 1 + ((st && fidx < vl && !inc) ? 1 : 0);
        exp_cr = '0;
        for (int i = 0; i < pc; i++) exp_cr[4*i +: 4] = cr_of(dv[i]);
        acc0 = acc_cnt;
        launch(vl, st, ra, rt, 64'(8 * iw), sel, tv, inc);
        chk("R10 done latency", 64'(cyc), 64'(exp_cyc));
        chk("R5 final length", 64'(vl_out), 64'((fidx < vl) ? (inc ? fidx + 1 : fidx) : vl));
        chk("R3 condition fields", 64'(cr_fields), 64'(exp_cr));
        chk("R1 access count", 64'(acc_cnt - acc0), 64'(acc));
        for (int i = 0; i < 8; i++) begin
            if (st) begin
                e = (i < fidx || (i == fidx && inc && fidx < vl)) ? dv[i] : SENT;
                chk(i == fidx ? (inc ? "R7 inclusive store" : "R6 rejected store")
                              : "R4 store word", mem[iw + i], e);
            end else begin
                get_reg((rt + i) % 16, v);
                chk("R4 R2 load destination", v, (i < pc) ? dv[i] : SENT);
            end
        end
    endtask

    initial begin
        logic [63:0] v;
        int acc0;
        for (int i = 0; i < 128; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 done after reset", 64'(done), 64'(0));
        chk("R11 vl_out after reset", 64'(vl_out), 64'(0));
        chk("R11 fields after reset", 64'(cr_fields), 64'(0));
        chk("R11 no request in reset", 64'(mem_req), 64'(0));
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R11 idle after reset", 64'(mem_req), 64'(0));

        // Loads and stores, zero-test, every stop position, both modes.
        for (int st = 0; st < 2; st++)
            for (int vl = 1; vl <= 8; vl++)
                for (int f = 0; f <= vl; f++)
                    for (int inc = 0; inc < 2; inc++) begin
                        for (int i = 0; i < 8; i++)
                            dv[i] = (i == f) ? 64'd0 : ((i % 2) ? -64'(i + 3) : 64'(i + 7));
                        run_case(st[0], vl, 1, 1'b1, inc[0], 0, 8, st ? 64 : 16);
                    end

        // R4: stop on non-negative (negative bit, test 0).
        for (int f = 0; f <= 8; f++)
            for (int inc = 0; inc < 2; inc++) begin
                for (int i = 0; i < 8; i++)
                    dv[i] = (i == f) ? ((f % 2) ? 64'd0 : 64'd5) : -64'(i + 1);
                run_case(1'b0, 8, 3, 1'b0, inc[0], 0, 8, 16);
            end

        // R4: stop on positive (positive bit, test 1), store direction.
        for (int f = 0; f <= 8; f++) begin
            for (int i = 0; i < 8; i++)
                dv[i] = (i == f) ? 64'(100 + i) : -64'(i);
            run_case(1'b1, 8, 2, 1'b1, 1'b0, 0, 8, 64);
        end

        // R3/R5: bit 0 is always 0, so test 1 never stops and test 0 stops at once.
        for (int i = 0; i < 8; i++) dv[i] = 64'(i) - 64'd3;
        run_case(1'b0, 6, 0, 1'b1, 1'b1, 0, 8, 16);
        run_case(1'b0, 6, 0, 1'b0, 1'b1, 0, 8, 16);

        // R1: register index wraps modulo 16.
        for (int i = 0; i < 8; i++) dv[i] = 64'(i + 1);
        run_case(1'b0, 4, 1, 1'b1, 1'b0, 14, 4, 16);

        // R2: pointer chasing with rt = ra + 1; node k at byte 80*(k+1), next at +8.
        for (int k = 0; k < 4; k++) mem[10 * (k + 1) + 1] = (k < 3) ? 64'(80 * (k + 2)) : 64'd0;
        for (int inc = 0; inc < 2; inc++) begin
            set_reg(0, 64'd80);
            for (int r = 1; r < 6; r++) set_reg(r, SENT);
            launch(5, 1'b0, 0, 1, 64'd8, 1, 1'b1, inc[0]);
            chk("R2 chase length", 64'(vl_out), 64'(inc ? 4 : 3));
            for (int r = 1; r <= 4; r++) begin
                get_reg(r, v);
                chk("R2 chased pointer", v, (r < 4) ? 64'(80 * (r + 1)) : 64'd0);
            end
            get_reg(5, v);
            chk("R4 beyond stop untouched", v, SENT);
        end

        // R8: zero length.
        acc0 = acc_cnt;
        launch(0, 1'b0, 0, 8, 64'd0, 1, 1'b1, 1'b0);
        chk("R8 zero length latency", 64'(cyc), 64'd1);
        chk("R8 zero length result", 64'(vl_out), 64'd0);
        chk("R8 zero length no access", 64'(acc_cnt - acc0), 64'd0);
        chk("R8 zero length fields", 64'(cr_fields), 64'd0);

        // R9: start during a run is ignored; results then hold.
        for (int i = 0; i < 4; i++) begin
            set_reg(i, 64'(8 * i));
            mem[16 + i] = 64'(50 + i);
        end
        acc0 = acc_cnt;
        @(negedge clk);
        vl_in = 4'd4; is_store = 1'b0; ra_idx = 4'd0; rt_idx = 4'd8; imm = 64'd128;
        test_sel = 2'd1; test_val = 1'b1; inclusive = 1'b0; start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        chk("R9 done drops on start", 64'(done), 64'd0);
        @(posedge clk); @(negedge clk);
        vl_in = 4'd1; start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 200) begin @(posedge clk); @(negedge clk); cyc++; end
        chk("R9 busy start ignored length", 64'(vl_out), 64'd4);
        chk("R9 busy start ignored accesses", 64'(acc_cnt - acc0), 64'd4);
        vl_in = 4'd7; inclusive = 1'b1;
        repeat (6) @(negedge clk);
        chk("R9 done holds", 64'(done), 64'd1);
        chk("R9 length holds", 64'(vl_out), 64'd4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule